// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is handed on to the receive path. The decision depends only on the frame's 48-bit destination address. When the receive logic has the destination in hand, it presents the address together with a one-cycle valid strobe. One clock later the block returns a registered verdict. The verdict is an accept bit plus three indicators:

- the destination equals the station address;
- the destination is the all-ones broadcast address;
- the destination is a group (multicast) address.

The station address is loaded from two configuration words. The first is a 32-bit word holding address bytes 0 to 3, with byte 0 in its least significant bits. The second is a 16-bit word holding bytes 4 and 5. The assembled address can be read back as three 16-bit halves.

There are three acceptance rules:

- Promiscuous operation accepts every frame.
- Every group-addressed frame is accepted without any hash filtering.
- Any other frame is accepted only when all six destination bytes equal the station address.

Throughout, byte k of a 48-bit address is bits 8k+7:8k, and byte 0 is the first byte on the wire.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted, and after it until the first destination strobe, `dec_valid`, `accept`, `phys_hit`, `bcast_hit` and `group_hit` are 0. The three station halves read 0 until a load.
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `dst_valid` high, and 0 otherwise.
- R3: When `promisc_en` is 1 in the strobe cycle, `accept` is 1 regardless of the destination.
- R4: A destination with bit 0 of byte 0 (`dst_addr[0]`) set is a group address. It gives `group_hit` = 1 and `accept` = 1.
- R5: With `promisc_en` = 0 and an individual destination, `accept` equals `phys_hit`. `phys_hit` is 1 exactly when all 48 destination bits equal the station address.
- R6: `bcast_hit` is 1 exactly when the destination is 48'hFFFF_FFFF_FFFF. Such a destination is also a group address.
- R7: On `cfg_load`, station bytes 0..3 take `cfg_word_a[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`, and bytes 4..5 take `cfg_word_b[7:0]` and `[15:8]`. The readback is `sta_w0` = `cfg_word_a[15:0]`, `sta_w1` = `cfg_word_a[31:16]` and `sta_w2` = `cfg_word_b`, visible the cycle after the load.
- R8: In cycles without `dst_valid`, the verdict outputs hold their last values, whatever `dst_addr` or `promisc_en` do.
- R9: A strobe in the same cycle as `cfg_load` is judged against the station address held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load station address from the two words |
| cfg_word_a | input | 32 | Station address bytes 0..3, byte 0 in bits 7:0 |
| cfg_word_b | input | 16 | Station address bytes 4..5, byte 4 in bits 7:0 |
| promisc_en | input | 1 | Promiscuous operation: accept all frames |
| dst_valid | input | 1 | Destination address present this cycle |
| dst_addr | input | 48 | Destination address, byte k in bits 8k+7:8k |
| dec_valid | output | 1 | Verdict valid (one cycle after dst_valid) |
| accept | output | 1 | Frame is to be delivered |
| phys_hit | output | 1 | Destination equals station address |
| bcast_hit | output | 1 | Destination is all ones |
| group_hit | output | 1 | Destination is a group address |
| sta_w0 | output | 16 | Station address bytes 1:0 |
| sta_w1 | output | 16 | Station address bytes 3:2 |
| sta_w2 | output | 16 | Station address bytes 5:4 |

## Verification
The assertions assume two things about the inputs:

- `dst_valid` is a clean per-frame strobe that is sampled together with `dst_addr` and `promisc_en` in the same cycle.
- Any station reload that matters to a frame either precedes that frame's strobe or coincides with it.

The stimulus drives every input on the falling edge, so each strobe lasts exactly one clock with its address and mode already settled. The stimulus changes `dst_addr` and `promisc_en` freely between strobes, to show they have no effect until the next strobe. Loads are issued only with fully known words, including one load placed in the same cycle as a strobe to show the old address is used.

// File: rtl/rx_daf_pkg.sv
package rx_daf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic accept;
    logic phys;
    logic bcast;
    logic group;
  } daf_verdict_t;
endpackage

// File: rtl/daf_rst_sync.sv
module daf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/daf_station_reg.sv
module daf_station_reg #(
  parameter int unsigned WORD_A_W = 32,
  parameter int unsigned WORD_B_W = 16,
  parameter int unsigned HALF_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [WORD_A_W-1:0]          word_a,
  input  logic [WORD_B_W-1:0]          word_b,
  output logic [WORD_A_W+WORD_B_W-1:0] station,
  output logic [HALF_W-1:0]            half0,
  output logic [HALF_W-1:0]            half1,
  output logic [HALF_W-1:0]            half2
);
  import rx_daf_pkg::*;
  localparam int unsigned ADDR_W  = WORD_A_W + WORD_B_W;
  localparam int unsigned A_BYTES = WORD_A_W / BYTE_W;
  localparam int unsigned N_BYTES = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] sta_q;
  logic [ADDR_W-1:0] sta_d;
  logic [ADDR_W-1:0] assembled;

  // Byte k of the station address: low word first, least significant byte first.
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    if (k < A_BYTES) begin : g_from_a
      assign assembled[k*BYTE_W +: BYTE_W] = word_a[k*BYTE_W +: BYTE_W];
    end else begin : g_from_b
      assign assembled[k*BYTE_W +: BYTE_W] = word_b[(k-A_BYTES)*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    sta_d = sta_q;
    if (load) sta_d = assembled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta_q <= '0;
    else        sta_q <= sta_d;
  end

  assign station = sta_q;
  assign half0   = sta_q[0*HALF_W +: HALF_W];
  assign half1   = sta_q[1*HALF_W +: HALF_W];
  assign half2   = sta_q[2*HALF_W +: HALF_W];

  // R7
  load_low_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (half0 == $past(word_a[HALF_W-1:0])) && (half1 == $past(word_a[WORD_A_W-1:HALF_W])));
  // R7
  load_high_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> half2 == $past(word_b));
  // R7
  hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(station));
endmodule

// File: rtl/daf_classifier.sv
module daf_classifier #(
  parameter int unsigned N_BYTES = 6
) (
  input  logic [N_BYTES*8-1:0] dst,
  input  logic [N_BYTES*8-1:0] station,
  input  logic                 promisc,
  output rx_daf_pkg::daf_verdict_t verdict
);
  import rx_daf_pkg::*;

  logic [N_BYTES-1:0] byte_eq;
  logic [N_BYTES-1:0] byte_ones;
  logic               phys;
  logic               bcast;
  logic               group;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_cmp
    assign byte_eq[k]   = (dst[k*BYTE_W +: BYTE_W] == station[k*BYTE_W +: BYTE_W]);
    assign byte_ones[k] = &dst[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    phys  = &byte_eq;
    bcast = &byte_ones;
    group = dst[0];
    verdict.phys   = phys;
    verdict.bcast  = bcast;
    verdict.group  = group;
    verdict.accept = promisc | group | phys;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned WORD_A_W = 32,
  parameter int unsigned WORD_B_W = 16,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_load,
  input  logic [WORD_A_W-1:0]          cfg_word_a,
  input  logic [WORD_B_W-1:0]          cfg_word_b,
  input  logic                         promisc_en,
  input  logic                         dst_valid,
  input  logic [WORD_A_W+WORD_B_W-1:0] dst_addr,
  output logic                         dec_valid,
  output logic                         accept,
  output logic                         phys_hit,
  output logic                         bcast_hit,
  output logic                         group_hit,
  output logic [HALF_W-1:0]            sta_w0,
  output logic [HALF_W-1:0]            sta_w1,
  output logic [HALF_W-1:0]            sta_w2
);
  import rx_daf_pkg::*;
  localparam int unsigned ADDR_W  = WORD_A_W + WORD_B_W;
  localparam int unsigned N_BYTES = ADDR_W / BYTE_W;

  logic              rst_n_i;
  logic [ADDR_W-1:0] station;
  daf_verdict_t      verdict_c;
  daf_verdict_t      verdict_q;
  daf_verdict_t      verdict_d;
  logic              vld_q;
  logic              vld_d;

  daf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_i)
  );

  daf_station_reg #(.WORD_A_W(WORD_A_W), .WORD_B_W(WORD_B_W), .HALF_W(HALF_W)) u_sta (
    .clk(clk), .rst_n(rst_n_i), .load(cfg_load),
    .word_a(cfg_word_a), .word_b(cfg_word_b),
    .station(station), .half0(sta_w0), .half1(sta_w1), .half2(sta_w2)
  );

  daf_classifier #(.N_BYTES(N_BYTES)) u_cls (
    .dst(dst_addr), .station(station), .promisc(promisc_en), .verdict(verdict_c)
  );

  always_comb begin
    vld_d     = dst_valid;
    verdict_d = verdict_q;
    if (dst_valid) verdict_d = verdict_c;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_q     <= 1'b0;
      verdict_q <= '0;
    end else begin
      vld_q     <= vld_d;
      verdict_q <= verdict_d;
    end
  end

  assign dec_valid = vld_q;
  assign accept    = verdict_q.accept;
  assign phys_hit  = verdict_q.phys;
  assign bcast_hit = verdict_q.bcast;
  assign group_hit = verdict_q.group;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    dst_valid |=> dec_valid);
  // R2
  valid_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !dst_valid |=> !dec_valid);
  // R3
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dst_valid && promisc_en) |=> accept);
  // R4
  group_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dst_valid && dst_addr[0]) |=> (accept && group_hit));
  // R5
  unicast_rule_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dst_valid && !promisc_en && !dst_addr[0]) |=> (accept == phys_hit));
  // R6
  bcast_is_group_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    bcast_hit |-> group_hit);
  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !dst_valid |=> ($stable(accept) && $stable(phys_hit) && $stable(bcast_hit) && $stable(group_hit)));
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_word_a;
  logic [15:0] cfg_word_b;
  logic        promisc_en;
  logic        dst_valid;
  logic [47:0] dst_addr;
  logic        dec_valid, accept, phys_hit, bcast_hit, group_hit;
  logic [15:0] sta_w0, sta_w1, sta_w2;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word_a(cfg_word_a),
    .cfg_word_b(cfg_word_b), .promisc_en(promisc_en), .dst_valid(dst_valid),
    .dst_addr(dst_addr), .dec_valid(dec_valid), .accept(accept),
    .phys_hit(phys_hit), .bcast_hit(bcast_hit), .group_hit(group_hit),
    .sta_w0(sta_w0), .sta_w1(sta_w1), .sta_w2(sta_w2)
  );

  // {promisc, dst, accept, phys, bcast, group}; station = 9A78_5634_1202
  localparam int NV = 10;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 48'h9A78_5634_1202, 4'b1100},
    {1'b0, 48'h9A78_5634_1203, 4'b1001},
    {1'b0, 48'h9A78_5634_1204, 4'b0000},
    {1'b0, 48'hFFFF_FFFF_FFFF, 4'b1011},
    {1'b1, 48'h0000_0000_0010, 4'b1000},
    {1'b0, 48'h0000_0000_0010, 4'b0000},
    {1'b0, 48'h1A78_5634_1202, 4'b0000},
    {1'b1, 48'h9A78_5634_1202, 4'b1100},
    {1'b0, 48'h9A78_5634_1282, 4'b0000},
    {1'b0, 48'h0000_0000_0001, 4'b1001}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {accept, phys_hit, bcast_hit, group_hit};
  endfunction

  task automatic strobe(input logic pm, input logic [47:0] d);
    @(negedge clk);
    promisc_en = pm; dst_addr = d; dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [15:0] b);
    @(negedge clk);
    cfg_word_a = a; cfg_word_b = b; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word_a = '0; cfg_word_b = '0;
    promisc_en = 1'b0; dst_valid = 1'b0; dst_addr = '0;
    #20;
    // R1 reset state
    check("R1 verdict", {59'd0, dec_valid, flags()}, 64'd0);
    check("R1 station", {16'd0, sta_w2, sta_w1, sta_w0}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {59'd0, dec_valid, flags()}, 64'd0);

    load(32'h5634_1202, 16'h9A78);
    // R7 readback order
    check("R7 sta_w0", {48'd0, sta_w0}, 64'h1202);
    check("R7 sta_w1", {48'd0, sta_w1}, 64'h5634);
    check("R7 sta_w2", {48'd0, sta_w2}, 64'h9A78);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][52], VEC[i][51:4]);
      // R2 R3 R4 R5 R6 vector checks
      check($sformatf("R2 vec%0d valid", i), {63'd0, dec_valid}, 64'd1);
      check($sformatf("R3/R4/R5/R6 vec%0d flags", i), {60'd0, flags()}, {60'd0, VEC[i][3:0]});
    end

    // R2: valid drops when no strobe
    @(negedge clk);
    check("R2 idle", {63'd0, dec_valid}, 64'd0);

    // R8: hold after accept with noisy inputs
    strobe(1'b0, 48'hFFFF_FFFF_FFFF);
    dst_addr = 48'h0000_0000_0004; promisc_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 hold flags", {60'd0, flags()}, 64'hB);
    check("R8 no valid", {63'd0, dec_valid}, 64'd0);
    promisc_en = 1'b0;

    // R9: load and strobe in same cycle use old station
    @(negedge clk);
    cfg_word_a = 32'h0403_0200; cfg_word_b = 16'h0605; cfg_load = 1'b1;
    dst_addr = 48'h9A78_5634_1202; dst_valid = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; dst_valid = 1'b0;
    check("R9 old station", {60'd0, flags()}, 64'hC);
    strobe(1'b0, 48'h9A78_5634_1202);
    check("R9 old gone", {60'd0, flags()}, 64'h0);
    strobe(1'b0, 48'h0605_0403_0200);
    check("R5 new station", {60'd0, flags()}, 64'hC);
    check("R7 new readback", {16'd0, sta_w2, sta_w1, sta_w0}, 64'h0000_0605_0403_0200);

    // R1: reset mid-run clears verdict and station
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R1 rerun", {59'd0, dec_valid, flags()}, 64'd0);
    check("R1 rerun station", {16'd0, sta_w2, sta_w1, sta_w0}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule